// File: doc/BRIEF.md
# ETU Rate Generator with Period Compensation

This block paces a smart-card style serial link. It counts the peripheral clock and divides it by a programmable 12-bit value. It emits a one-cycle `etu_tick` in the last clock of every elementary time unit (ETU). It also emits a one-cycle `mid_strobe` near the middle of each ETU, which a receiver uses to sample data bits. A framing engine pulses `restart` on a start-bit edge so that the ETU grid lines up with the incoming character.

With compensation enabled, the period length alternates between a long and a short value. This approximates a divide ratio half a clock below the plain one. Configuration writes are screened and double-buffered. A divider of 4 or less is dropped. A valid write is held in a pending copy and becomes active only at a period boundary.

The core is a three-state phase machine:
- `ETU_OFF`: disabled, counter held at zero.
- `ETU_LONG`: the current period is the long one.
- `ETU_SHORT`: the current period is the short one.

Its transitions are:
- OFF→LONG when `enable` is seen high.
- LONG→SHORT on a tick.
- SHORT→LONG on a tick.
- LONG or SHORT →LONG on `restart`.
- Any state →OFF when `enable` is low.

The phase toggles on every tick. Without compensation both phases have the same length.

Top module: `etu_rate_gen`

## Requirements
Timing convention used below: a period starts at the clock edge after a tick, or at the edge that samples `restart` or a rising `enable`. A period of length L has its tick in its L-th clock cycle. It has its strobe in cycle floor(L/2)+1.

- R1: With compensation off and active divider D, every period is D+1 clock cycles long.
- R2: With compensation on, periods alternate D+1 (long) and D (short). The first period after restart or enable is the long one, and the next is short.
- R3: `mid_strobe` is high for exactly one cycle per period, in cycle floor(L/2)+1, where L is that period's length. It never coincides with `etu_tick`.
- R4: A configuration write with `cfg_div` ≤ 4 is ignored entirely. Neither the divider nor the compensation setting changes, and the following periods keep their previous lengths.
- R5: A valid write made mid-period does not change the current period's length. It takes effect from the next period onward.
- R6: `restart` while enabled clears the counter and forces the long phase. The next tick comes one full long period later.
- R7: While `enable` is low, `etu_tick` and `mid_strobe` stay low. On re-enable, the first period is a full long period.
- R8: After reset, both outputs are low. The active divider is the reset value 371 (a 372-cycle period), with compensation off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Engine enable; low holds outputs low and counter at zero |
| restart | input | 1 | Realign pulse from the start-bit detector |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_div | input | 12 | Divider value D (valid when greater than 4) |
| cfg_comp | input | 1 | Compensation enable written with the divider |
| etu_tick | output | 1 | One-cycle pulse in the last cycle of each ETU |
| mid_strobe | output | 1 | One-cycle pulse near mid-ETU for sampling |

## Verification
A table of divider and compensation pairs measures three consecutive periods and two strobe positions after each restart. The table includes the smallest legal divider in both modes, even and odd dividers, and the largest divider. These cases separate a fixed period from an alternating one and catch an off-by-one on the long or short length. Odd and even period lengths expose rounding errors in the strobe position. Directed sequences then try the following:
- A mid-period divider change, which separates deferred loading from immediate loading.
- Illegal writes carrying a compensation request, which show whether rejection covers the whole write.
- A restart during a short period, which shows whether the phase is reset.
- A disable and re-enable, which shows the outputs are silenced and the first period is full.

// File: rtl/etu_pkg.sv
package etu_pkg;
    typedef enum logic [1:0] {
        ETU_OFF   = 2'd0,
        ETU_LONG  = 2'd1,
        ETU_SHORT = 2'd2
    } etu_state_e;
endpackage

// File: rtl/etu_cfg_shadow.sv
module etu_cfg_shadow #(
    parameter int DW      = 12,
    parameter int MIN_DIV = 4,
    parameter int RST_DIV = 371
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [DW-1:0] cfg_div,
    input  logic          cfg_comp,
    input  logic          load,
    output logic [DW-1:0] act_div,
    output logic          act_comp
);
    logic [DW-1:0] pend_div;
    logic          pend_comp;
    logic          wr_ok;

    assign wr_ok = cfg_we && (cfg_div > DW'(MIN_DIV));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_div  <= DW'(RST_DIV);
            pend_comp <= 1'b0;
        end else if (wr_ok) begin
            pend_div  <= cfg_div;
            pend_comp <= cfg_comp;
        end
    end

    // Active copy changes only at a period boundary; a write in that
    // same cycle is forwarded so it is not delayed by a whole period.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_div  <= DW'(RST_DIV);
            act_comp <= 1'b0;
        end else if (load) begin
            act_div  <= wr_ok ? cfg_div  : pend_div;
            act_comp <= wr_ok ? cfg_comp : pend_comp;
        end
    end
endmodule

// File: rtl/etu_phase_fsm.sv
module etu_phase_fsm
    import etu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       restart,
    input  logic       tick,
    output etu_state_e state,
    output logic       running,
    output logic       short_ph,
    output logic       bound
);
    etu_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ETU_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!enable) begin
            state_nx = ETU_OFF;
        end else begin
            unique case (state)
                ETU_OFF:   state_nx = ETU_LONG;
                ETU_LONG:  state_nx = (!restart && tick) ? ETU_SHORT : ETU_LONG;
                ETU_SHORT: state_nx = (restart || tick) ? ETU_LONG : ETU_SHORT;
                default:   state_nx = ETU_OFF;
            endcase
        end
    end

    always_comb begin
        running  = enable && (state != ETU_OFF);
        short_ph = (state == ETU_SHORT);
        bound    = (state == ETU_OFF) || tick || restart;
    end
endmodule

// File: rtl/etu_counter.sv
module etu_counter #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          running,
    input  logic          restart,
    input  logic          short_sel,
    input  logic [DW-1:0] act_div,
    output logic          tick,
    output logic          strobe
);
    logic [DW-1:0] cnt;
    logic [DW-1:0] last;
    logic [DW:0]   len_w;
    logic [DW:0]   half_w;

    always_comb begin
        last   = short_sel ? (act_div - DW'(1)) : act_div;
        len_w  = (DW+1)'(last) + (DW+1)'(1);
        half_w = len_w >> 1;
        tick   = running && (cnt == last);
        strobe = running && (cnt == half_w[DW-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt <= '0;
        else if (!running || restart)  cnt <= '0;
        else if (cnt == last)          cnt <= '0;
        else                           cnt <= cnt + DW'(1);
    end
endmodule

// File: rtl/etu_rate_gen.sv
module etu_rate_gen
    import etu_pkg::*;
#(
    parameter int DIV_W   = 12,
    parameter int MIN_DIV = 4,
    parameter int RST_DIV = 371
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             restart,
    input  logic             cfg_we,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_comp,
    output logic             etu_tick,
    output logic             mid_strobe
);
    etu_state_e       state;
    logic             running;
    logic             short_ph;
    logic             bound;
    logic [DIV_W-1:0] act_div;
    logic             act_comp;

    etu_cfg_shadow #(.DW(DIV_W), .MIN_DIV(MIN_DIV), .RST_DIV(RST_DIV)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_div(cfg_div),
        .cfg_comp(cfg_comp), .load(bound), .act_div(act_div), .act_comp(act_comp)
    );

    etu_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .restart(restart),
        .tick(etu_tick), .state(state), .running(running),
        .short_ph(short_ph), .bound(bound)
    );

    etu_counter #(.DW(DIV_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .running(running), .restart(restart),
        .short_sel(act_comp && short_ph), .act_div(act_div),
        .tick(etu_tick), .strobe(mid_strobe)
    );
endmodule

// File: rtl/etu_rate_gen_chk.sv
module etu_rate_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic restart,
    input logic etu_tick,
    input logic mid_strobe
);
    logic [15:0] gap;
    logic [1:0]  seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= '0;
        end else if (!enable || restart || etu_tick) begin
            gap  <= '0;
            seen <= '0;
        end else begin
            if (gap != 16'hFFFF) gap <= gap + 16'd1;
            if (mid_strobe && seen != 2'd3) seen <= seen + 2'd1;
        end
    end

    a_r7_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!etu_tick && !mid_strobe));

    a_r6_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && restart) |=> (!etu_tick && !mid_strobe));

    a_r4_min_period: assert property (@(posedge clk) disable iff (!rst_n)
        etu_tick |-> (gap >= 16'd4));

    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (etu_tick && !$past(restart)) |-> (seen == 2'd1));

    a_r3_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(etu_tick && mid_strobe));
endmodule

bind etu_rate_gen etu_rate_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .restart(restart),
    .etu_tick(etu_tick), .mid_strobe(mid_strobe)
);

// File: tb/sim_etu_rate_gen.sv
`timescale 1ns/1ps
module sim_etu_rate_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        restart = 1'b0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_div = '0;
    logic        cfg_comp = 1'b0;
    logic        etu_tick;
    logic        mid_strobe;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    etu_rate_gen u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .restart(restart),
        .cfg_we(cfg_we), .cfg_div(cfg_div), .cfg_comp(cfg_comp),
        .etu_tick(etu_tick), .mid_strobe(mid_strobe)
    );

    // {comp, divider}
    localparam logic [12:0] VEC [0:5] = '{
        {1'b0, 12'd5}, {1'b1, 12'd5}, {1'b1, 12'd6},
        {1'b1, 12'd10}, {1'b0, 12'd4095}, {1'b0, 12'd9}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Current negedge sample is observation 'first'; returns the tick index.
    task automatic gap(input int first, output int n, output int s);
        n = first;
        s = 0;
        forever begin
            if (mid_strobe && s == 0) s = n;
            if (etu_tick) break;
            if (n > 5000) begin n = -1; break; end
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #(5.0 * 190000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int n, s, cnt, d, l1, l2;
        logic c;
        repeat (3) @(negedge clk);
        check("R8 tick in reset", int'(etu_tick), 0);
        check("R8 strobe in reset", int'(mid_strobe), 0);
        rst_n = 1'b1;
        cnt = 0;
        repeat (20) begin
            @(negedge clk);
            cnt += int'(etu_tick) + int'(mid_strobe);
        end
        check("R7 quiet before enable", cnt, 0);

        // R8 default divider
        enable = 1'b1;
        @(negedge clk);
        gap(1, n, s);
        check("R8 default period", n, 372);
        check("R8 default strobe", s, 187);

        // Table walk (R1 R2 R3)
        for (int i = 0; i < 6; i++) begin
            d = int'(VEC[i][11:0]);
            c = VEC[i][12];
            l1 = d + 1;
            l2 = c ? d : d + 1;
            @(negedge clk);
            cfg_div = VEC[i][11:0]; cfg_comp = c; cfg_we = 1'b1; restart = 1'b1;
            @(negedge clk);
            cfg_we = 1'b0; restart = 1'b0;
            gap(1, n, s);
            check(c ? "R2 first long period" : "R1 fixed period", n, l1);
            check("R3 strobe first period", s, (l1 / 2) + 1);
            @(negedge clk);
            gap(1, n, s);
            check(c ? "R2 short period" : "R1 fixed period 2", n, l2);
            check("R3 strobe second period", s, (l2 / 2) + 1);
            @(negedge clk);
            gap(1, n, s);
            check("R2 third period long", n, l1);
        end

        // R5: mid-period change applies at next boundary (active D=9, no comp)
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        @(negedge clk);
        cfg_div = 12'd20; cfg_comp = 1'b0; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        gap(3, n, s);
        check("R5 current period kept", n, 10);
        @(negedge clk);
        gap(1, n, s);
        check("R5 new period applied", n, 21);

        // R4: illegal writes ignored, including their compensation bit
        @(negedge clk);
        cfg_div = 12'd4; cfg_comp = 1'b1; cfg_we = 1'b1;
        @(negedge clk);
        cfg_div = 12'd0;
        @(negedge clk);
        cfg_we = 1'b0; cfg_comp = 1'b0;
        gap(3, n, s);
        check("R4 period after bad write", n, 21);
        @(negedge clk);
        gap(1, n, s);
        check("R4 no compensation taken", n, 21);

        // R6: restart inside a short period returns to long phase
        @(negedge clk);
        cfg_div = 12'd9; cfg_comp = 1'b1; cfg_we = 1'b1; restart = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; restart = 1'b0;
        gap(1, n, s);
        check("R6 long after restart", n, 10);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        gap(1, n, s);
        check("R6 realigned long period", n, 10);
        @(negedge clk);
        gap(1, n, s);
        check("R6 short follows", n, 9);

        // R7: disable silences outputs; re-enable starts a full long period
        @(negedge clk);
        enable = 1'b0;
        cnt = 0;
        repeat (40) begin
            @(negedge clk);
            cnt += int'(etu_tick) + int'(mid_strobe);
        end
        check("R7 quiet while disabled", cnt, 0);
        enable = 1'b1;
        @(negedge clk);
        gap(1, n, s);
        check("R7 first period after enable", n, 10);
        @(negedge clk);
        gap(1, n, s);
        check("R7 then short period", n, 9);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule